// File: doc/BRIEF.md
# Barrel Shifter with Carry Output

This block is the shift stage of a small processor datapath. It is purely combinational. It takes an operand, an unsigned shift distance and a two-bit operation select, and produces the shifted result in the same cycle. It supports logical left, logical right, arithmetic right and rotate right.

Next to the result it computes a new carry flag, equal to the last bit that left the operand. A write-enable tells the flag logic whether that carry should be stored. A zero distance leaves both the operand and the carry untouched, and the write-enable stays low.

The distance is the low byte of a register, so it can be larger than the operand width. Each operation defines its own result and carry for distances at or beyond the width.

Top module: `shift_carry_unit`

## Requirements
- R1: The operation select encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a distance n with 1 <= n < DATA_W, a logical shift moves the operand n places and fills the vacated positions with zeros.
- R2: When the distance is 0, the result equals the operand and carry_o equals carry_i, for every operation.
- R3: carry_we_o is 1 exactly when the distance is nonzero.
- R4: An arithmetic right shift by n (1 <= n < DATA_W) fills the top n bits with the operand's sign bit and returns operand bit n-1 as carry. This is signed division by 2^n rounded toward minus infinity, so -5 shifted by 1 gives -3.
- R5: An arithmetic right shift by DATA_W or more gives DATA_W copies of the sign bit, and the carry equals the sign bit.
- R6: A logical left shift by n (1 <= n <= DATA_W) returns operand bit DATA_W-n as carry; at n = DATA_W the result is 0 and the carry is bit 0. Above DATA_W both the result and the carry are 0.
- R7: A logical right shift by n (1 <= n <= DATA_W) returns operand bit n-1 as carry; at n = DATA_W the result is 0 and the carry is the top bit. Above DATA_W both the result and the carry are 0.
- R8: A rotate right uses the distance modulo DATA_W, and for any nonzero distance the carry equals the result's top bit. A nonzero multiple of DATA_W returns the operand unchanged, with the carry equal to its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | DATA_W | Operand to be shifted |
| amt_i | input | AMT_W | Unsigned shift distance |
| op_i | input | 2 | Operation select (encoding in R1) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | DATA_W | Shifted result |
| carry_o | output | 1 | New carry flag |
| carry_we_o | output | 1 | High when the carry should be written back |

## Verification
The bench builds two copies of the block. The first uses the full 32-bit width with an 8-bit distance. It is driven with directed distances around 0, 1, 31, 32, 33 and the top of the byte range, together with random and patterned operands. The second copy is 8 bits wide with a 4-bit distance. That makes every combination of operation, distance, operand and incoming carry small enough to sweep, so each at-width and beyond-width case of every operation is covered for every operand bit pattern.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_op_e;
endpackage

// File: rtl/shf_amt_dec.sv
// Classifies the shift distance against the operand width.
module shf_amt_dec #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [AMT_W-1:0]         amt_i,
  output logic                     zero_o,
  output logic                     below_o,
  output logic                     exact_o,
  output logic                     above_o,
  output logic [$clog2(DATA_W)-1:0] low_o
);
  localparam int LG = $clog2(DATA_W);
  localparam logic [AMT_W:0] WIDTH_VAL = (AMT_W+1)'(DATA_W);

  logic [AMT_W:0] amt_ext;

  assign amt_ext = {1'b0, amt_i};
  assign zero_o  = (amt_i == '0);
  assign below_o = !zero_o && (amt_ext < WIDTH_VAL);
  assign exact_o = (amt_ext == WIDTH_VAL);
  assign above_o = (amt_ext > WIDTH_VAL);
  assign low_o   = amt_i[LG-1:0];
endmodule

// File: rtl/shf_barrel.sv
// Log-stage right shifter; incoming bits are the fill bit or wrapped bits.
module shf_barrel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         data_i,
  input  logic                      fill_i,
  input  logic                      rot_i,
  input  logic [$clog2(DATA_W)-1:0] dist_i,
  output logic [DATA_W-1:0]         data_o
);
  localparam int LG = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [0:LG];

  assign stage[0] = data_i;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [K-1:0] incoming;
    assign incoming = rot_i ? stage[s][K-1:0] : {K{fill_i}};
    assign stage[s+1] = dist_i[s] ? {incoming, stage[s][DATA_W-1:K]} : stage[s];
  end

  assign data_o = stage[LG];
endmodule

// File: rtl/shf_carry.sv
// Selects the last bit shifted out and gates the write-back.
module shf_carry
  import shf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         opnd_i,
  input  shift_op_e                 op_i,
  input  logic [$clog2(DATA_W)-1:0] low_i,
  input  logic                      zero_i,
  input  logic                      below_i,
  input  logic                      exact_i,
  input  logic                      rot_msb_i,
  input  logic                      carry_i,
  output logic                      carry_o,
  output logic                      carry_we_o
);
  localparam int LG = $clog2(DATA_W);

  function automatic logic last_out(
    input shift_op_e         op,
    input logic [DATA_W-1:0] d,
    input logic [LG-1:0]     n,
    input logic              below,
    input logic              exact,
    input logic              rmsb
  );
    logic [LG-1:0] left_idx;
    logic [LG-1:0] right_idx;
    logic          bit_out;
    left_idx  = ~n + 1'b1;   // DATA_W - n
    right_idx = n - 1'b1;    // n - 1
    unique case (op)
      SH_LSL:  bit_out = below ? d[left_idx]  : (exact ? d[0] : 1'b0);
      SH_LSR:  bit_out = below ? d[right_idx] : (exact ? d[DATA_W-1] : 1'b0);
      SH_ASR:  bit_out = below ? d[right_idx] : d[DATA_W-1];
      default: bit_out = rmsb;
    endcase
    return bit_out;
  endfunction

  assign carry_we_o = !zero_i;
  assign carry_o    = zero_i ? carry_i
                             : last_out(op_i, opnd_i, low_i, below_i, exact_i, rot_msb_i);
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [1:0]        op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o
);
  localparam int LG = $clog2(DATA_W);

  shift_op_e         op;
  logic              amt_zero;
  logic              amt_below;
  logic              amt_exact;
  logic              amt_above;
  logic [LG-1:0]     amt_low;
  logic              sign_bit;
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] core_in;
  logic [DATA_W-1:0] core_out;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] core_fix;

  assign op       = shift_op_e'(op_i);
  assign sign_bit = opnd_i[DATA_W-1];

  shf_amt_dec #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amt_i   (amt_i),
    .zero_o  (amt_zero),
    .below_o (amt_below),
    .exact_o (amt_exact),
    .above_o (amt_above),
    .low_o   (amt_low)
  );

  // Left shifts reuse the right shifter on the bit-reversed operand.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = opnd_i[DATA_W-1-i];
    assign rev_out[i] = core_out[DATA_W-1-i];
  end

  assign core_in = (op == SH_LSL) ? rev_in : opnd_i;

  shf_barrel #(.DATA_W(DATA_W)) u_bar (
    .data_i (core_in),
    .fill_i ((op == SH_ASR) && sign_bit),
    .rot_i  (op == SH_ROR),
    .dist_i (amt_low),
    .data_o (core_out)
  );

  assign core_fix = (op == SH_LSL) ? rev_out : core_out;

  always_comb begin
    if ((amt_exact || amt_above) && (op != SH_ROR)) begin
      result_o = (op == SH_ASR) ? {DATA_W{sign_bit}} : '0;
    end else begin
      result_o = core_fix;
    end
  end

  shf_carry #(.DATA_W(DATA_W)) u_car (
    .opnd_i     (opnd_i),
    .op_i       (op),
    .low_i      (amt_low),
    .zero_i     (amt_zero),
    .below_i    (amt_below),
    .exact_i    (amt_exact),
    .rot_msb_i  (core_out[DATA_W-1]),
    .carry_i    (carry_i),
    .carry_o    (carry_o),
    .carry_we_o (carry_we_o)
  );
endmodule

// File: rtl/shf_check.sv
module shf_check #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic [1:0]        op_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              carry_we_o,
  input logic              amt_zero,
  input logic              amt_below,
  input logic              amt_exact,
  input logic              amt_above
);
  logic far;
  assign far = amt_exact || amt_above;

  always_comb begin
    // R2
    zero_pass_chk: assert (!(amt_i == '0) || (amt_zero && result_o == opnd_i && carry_o == carry_i))
      else $error("zero distance changed operand or carry");
    // R3
    we_nonzero_chk: assert (carry_we_o == !amt_zero)
      else $error("carry write-enable disagrees with distance class");
    // R3
    amt_class_chk: assert ($onehot({amt_zero, amt_below, amt_exact, amt_above}))
      else $error("distance classes not exclusive");
    // R4
    asr_sign_chk: assert (!(op_i == 2'd2) || (result_o[DATA_W-1] == opnd_i[DATA_W-1]))
      else $error("arithmetic shift lost the sign");
    // R5
    asr_far_chk: assert (!(op_i == 2'd2 && far) || (result_o == {DATA_W{opnd_i[DATA_W-1]}} && carry_o == opnd_i[DATA_W-1]))
      else $error("arithmetic shift beyond width wrong");
    // R6
    lsl_far_chk: assert (!(op_i == 2'd0 && amt_above) || (result_o == '0 && !carry_o))
      else $error("left shift beyond width not cleared");
    // R7
    lsr_far_chk: assert (!(op_i == 2'd1 && amt_above) || (result_o == '0 && !carry_o))
      else $error("right shift beyond width not cleared");
    // R8
    ror_carry_chk: assert (!(op_i == 2'd3 && !amt_zero) || (carry_o == result_o[DATA_W-1]))
      else $error("rotate carry is not result top bit");
  end
endmodule

bind shift_carry_unit shf_check #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .opnd_i     (opnd_i),
  .amt_i      (amt_i),
  .op_i       (op_i),
  .carry_i    (carry_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .carry_we_o (carry_we_o),
  .amt_zero   (amt_zero),
  .amt_below  (amt_below),
  .amt_exact  (amt_exact),
  .amt_above  (amt_above)
);

// File: tb/shift_carry_unit_test.sv
module shift_carry_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // 32-bit copy
  logic [31:0] b_opnd = '0;
  logic [7:0]  b_amt  = '0;
  logic [1:0]  b_op   = '0;
  logic        b_cin  = 1'b0;
  logic [31:0] b_res;
  logic        b_cout, b_we;

  // 8-bit copy
  logic [7:0]  s_opnd = '0;
  logic [3:0]  s_amt  = '0;
  logic [1:0]  s_op   = '0;
  logic        s_cin  = 1'b0;
  logic [7:0]  s_res;
  logic        s_cout, s_we;

  shift_carry_unit #(.DATA_W(32), .AMT_W(8)) uut (
    .opnd_i(b_opnd), .amt_i(b_amt), .op_i(b_op), .carry_i(b_cin),
    .result_o(b_res), .carry_o(b_cout), .carry_we_o(b_we)
  );

  shift_carry_unit #(.DATA_W(8), .AMT_W(4)) uut_small (
    .opnd_i(s_opnd), .amt_i(s_amt), .op_i(s_op), .carry_i(s_cin),
    .result_o(s_res), .carry_o(s_cout), .carry_we_o(s_we)
  );

  // Serial model: one position per step, carry tracks the bit that leaves.
  function automatic logic [32:0] model(input int w, input logic [1:0] op,
                                        input logic [31:0] a, input int n, input logic cin);
    logic [31:0] mask;
    logic [31:0] r;
    logic        c;
    logic        b;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    r = a & mask;
    c = cin;
    for (int i = 0; i < n; i++) begin
      case (op)
        2'd0: begin c = r[w-1]; r = (r << 1) & mask; end
        2'd1: begin c = r[0];   r = r >> 1; end
        2'd2: begin c = r[0];   b = r[w-1]; r = (r >> 1) | (32'(b) << (w-1)); end
        default: begin b = r[0]; r = (r >> 1) | (32'(b) << (w-1)); end
      endcase
    end
    if (op == 2'd3 && n > 0) c = r[w-1];
    return {c, r};
  endfunction

  function automatic string tag_of(input int w, input logic [1:0] op, input int n);
    if (n == 0) return "R2";
    case (op)
      2'd0: return (n < w) ? "R1" : "R6";
      2'd1: return (n < w) ? "R1" : "R7";
      2'd2: return (n < w) ? "R4" : "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [31:0] got_r, input logic got_c,
                         input logic got_we, input logic [32:0] exp, input int n);
    checks++;
    if (got_r !== exp[31:0] || got_c !== exp[32]) begin
      errors++;
      $display("FAIL %s result/carry: got %h/%b expected %h/%b (n=%0d)",
               tag, got_r, got_c, exp[31:0], exp[32], n);
    end
    checks++;
    if (got_we !== (n != 0)) begin
      errors++;
      $display("FAIL R3 write-enable: got %b expected %b (n=%0d)", got_we, (n != 0), n);
    end
  endtask

  task automatic run_big(input logic [1:0] op, input logic [31:0] a, input int n, input logic cin);
    @(posedge clk);
    b_op = op; b_opnd = a; b_amt = 8'(n); b_cin = cin;
    @(negedge clk);
    compare(tag_of(32, op, n), b_res, b_cout, b_we, model(32, op, a, n, cin), n);
  endtask

  task automatic run_small(input logic [1:0] op, input logic [7:0] a, input int n, input logic cin);
    logic [32:0] e;
    @(posedge clk);
    s_op = op; s_opnd = a; s_amt = 4'(n); s_cin = cin;
    @(negedge clk);
    e = model(8, op, {24'b0, a}, n, cin);
    compare(tag_of(8, op, n), {24'b0, s_res}, s_cout, s_we, e, n);
  endtask

  int dlist [13] = '{0, 1, 2, 15, 30, 31, 32, 33, 63, 64, 96, 128, 255};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: zero inputs, zero distance (R2, R3)
    compare("R2", b_res, b_cout, b_we, 33'd0, 0);

    // R4: -5 >> 1 arithmetic gives -3, carry 1
    @(posedge clk);
    b_op = 2'd2; b_opnd = 32'hFFFF_FFFB; b_amt = 8'd1; b_cin = 1'b0;
    @(negedge clk);
    compare("R4", b_res, b_cout, b_we, {1'b1, 32'hFFFF_FFFD}, 1);

    // 32-bit copy: directed distances, patterned and random operands
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 13; k++) begin
        run_big(2'(op), 32'h8000_0001, dlist[k], 1'b1);
        run_big(2'(op), 32'h7FFF_FFFE, dlist[k], 1'b0);
        run_big(2'(op), 32'hA5C3_0F96, dlist[k], 1'b1);
        for (int r = 0; r < 6; r++) run_big(2'(op), $urandom, dlist[k], 1'($urandom));
      end
      for (int n = 0; n < 256; n++) run_big(2'(op), $urandom, n, 1'($urandom));
    end

    // 8-bit copy: full sweep of operation, distance, operand and carry
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 16; n++)
        for (int a = 0; a < 256; a++)
          for (int c = 0; c < 2; c++)
            run_small(2'(op), 8'(a), n, 1'(c));

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule